// File: doc/BRIEF.md
# Tunable Stochastic Bit Unit

This block is a cycle-accurate digital model of a probabilistic bit. It holds a single bipolar output, +1 or -1. Each time the update strobe is raised, it draws a fresh uniform pseudo-random value and compares it against a hyperbolic-tangent transfer of a signed fixed-point drive word. If the random value does not exceed the tanh threshold, the output becomes +1; otherwise it becomes -1. Zero drive therefore gives an unbiased coin. A strongly positive or negative drive pins the output toward +1 or -1. Averaged over many updates, the output follows tanh of the drive.

The random source is a 16-bit maximal-length shift register whose state can be replaced by a nonzero seed. The tanh transfer is a lookup table. The table contents are computed when the design elaborates, so no table is written out by hand. A parameter selects either a full table or a half table that uses odd symmetry. Between strobes, both the output and the random state are held.

Top module: `stoch_bit_unit`

## Requirements
- R1: `bit_out` encodes the bipolar value as 1 = +1 and 0 = -1. A synchronous active-high `rst` sets `bit_out` to 1 and the random state to 16'hACE1.
- R2: `bit_out` changes only in the cycle after a clock edge at which `upd_en` is high. In every other cycle it holds its value, whatever `drive_in` does.
- R3: On an update, the random value r is the current 16-bit random state read as a signed two's-complement fraction in [-1, +1). The new `bit_out` is 1 exactly when r <= t, where t is the tanh threshold for the `drive_in` present at that edge.
- R4: `drive_in` is signed with 4 fractional bits, so x = drive_in/16. For |x| <= 4, t equals round(32767*tanh(x)) to within 2 LSB.
- R5: For |x| > 4, t saturates to +32767 for positive drive and -32767 for negative drive. A drive above +4 always yields +1.
- R6: Each update advances the random state exactly once, as {s[14:0], s[15]^s[13]^s[12]^s[10]}. With no update and no seed load, the state does not change.
- R7: When `seed_ld` is high with a nonzero `seed_val`, the random state becomes `seed_val` at that edge. A load with a zero `seed_val` is ignored and leaves the state unchanged.
- R8: When `seed_ld` and `upd_en` are high at the same edge, the output decision uses the state from before the load, and the state then takes the seed rather than advancing.
- R9: The long-run average of the bipolar output is near 0 for zero drive and near tanh(x) otherwise. It rises monotonically from negative to positive drive.
- R10: When r equals t exactly, the output resolves to +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update strobe; one stochastic decision per high cycle |
| drive_in | input | 8 | Signed drive word, 4 fractional bits |
| seed_ld | input | 1 | Replace the random state with `seed_val` |
| seed_val | input | 16 | Seed word; zero is rejected |
| bit_out | output | 1 | Registered bipolar output, 1 = +1, 0 = -1 |

## Verification
On every cycle, the embedded assertions check the following:
- the output and the random state are held between strobes;
- a nonzero seed lands in the state one edge after the load;
- the state never reaches zero;
- any drive above the saturation limit produces +1.

Some behaviours only the bench scenarios can show. The exact decision on each update depends on the tanh table values, the shift polynomial and the pre-load state used in a combined load-and-update. The exact-tie rule only appears when seeds are chosen to hit the saturated thresholds. Averages that track tanh and rise monotonically only emerge over long runs, so they too are left to the bench.

// File: rtl/sbu_pkg.sv
`timescale 1ns/1ps
package sbu_pkg;

   localparam int QF = 30;

   // exp(2 / 2**frac_w) in Q30, by Taylor series
   function automatic longint exp_step_q30(input int frac_w);
      longint one;
      longint u;
      longint term;
      longint acc;
      one  = longint'(1) << QF;
      u    = longint'(1) << (QF + 1 - frac_w);
      term = one;
      acc  = one;
      for (int k = 1; k < 16; k++) begin
         term = ((term * u) >>> QF) / longint'(k);
         acc  = acc + term;
      end
      return acc;
   endfunction

   // tanh of one input LSB in Q30
   function automatic longint tanh_step_q30(input int frac_w);
      longint one;
      longint e;
      one = longint'(1) << QF;
      e   = exp_step_q30(frac_w);
      return ((e - one) <<< QF) / (e + one);
   endfunction

   // signed threshold for a signed input code v
   function automatic longint lut_entry(input longint v, input int frac_w,
                                        input int sat_int, input int out_w);
      longint one;
      longint a;
      longint t;
      longint mag;
      longint fs;
      longint res;
      one = longint'(1) << QF;
      fs  = (longint'(1) << (out_w - 1)) - 1;
      mag = (v < 0) ? -v : v;
      if (mag > (longint'(sat_int) << frac_w)) begin
         res = fs;
      end else begin
         a = tanh_step_q30(frac_w);
         t = 0;
         // tanh addition: tanh(p+q) = (tp+tq)/(1+tp*tq)
         for (longint k = 0; k < mag; k++) begin
            t = ((t + a) <<< QF) / (one + ((t * a) >>> QF));
         end
         res = (t * fs + (longint'(1) << (QF - 1))) >>> QF;
      end
      return (v < 0) ? -res : res;
   endfunction

   // Fibonacci feedback masks for maximal-length sequences
   function automatic longint lfsr_taps(input int w);
      case (w)
         8:       return longint'(64'h0000_00B8);
         16:      return longint'(64'h0000_B400);
         24:      return longint'(64'h00E1_0000);
         32:      return longint'(64'h8020_0003);
         default: return longint'(0);
      endcase
   endfunction

endpackage

// File: rtl/sbu_lfsr.sv
`timescale 1ns/1ps
module sbu_lfsr #(
   parameter int              W        = 16,
   parameter logic [W-1:0]    RST_SEED = W'(16'hACE1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);

   localparam longint       TAPS_L = sbu_pkg::lfsr_taps(W);
   localparam logic [W-1:0] TAPS   = TAPS_L[W-1:0];

   generate
      if (TAPS_L == 0) begin : g_bad_width
         $error("sbu_lfsr: unsupported width");
      end
      if (RST_SEED == '0) begin : g_bad_seed
         $error("sbu_lfsr: reset seed must be nonzero");
      end
   endgenerate

   logic         fb;
   logic [W-1:0] nxt;
   logic         seed_ok;

   assign fb      = ^(state & TAPS);
   assign nxt     = {state[W-2:0], fb};
   assign seed_ok = load && (seed != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= RST_SEED;
      end else if (seed_ok) begin
         state <= seed;
      end else if (step) begin
         state <= nxt;
      end
   end

   // R6
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(state));

   // R7
   seed_take_chk: assert property (@(posedge clk) disable iff (rst)
      (load && seed != '0) |=> (state == $past(seed)));

   // R7
   zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
      (load && seed == '0 && !step) |=> $stable(state));

   // R6
   lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
      (state != '0));

endmodule

// File: rtl/sbu_tanh_lut.sv
`timescale 1ns/1ps
module sbu_tanh_lut #(
   parameter int IN_W    = 8,
   parameter int FRAC_W  = 4,
   parameter int SAT_INT = 4,
   parameter int OUT_W   = 16,
   parameter bit FOLD    = 1'b1
) (
   input  logic signed [IN_W-1:0]  x,
   output logic signed [OUT_W-1:0] t
);

   localparam int DEPTH = 1 << IN_W;
   localparam int HALF  = DEPTH / 2 + 1;

   generate
      if (IN_W < 3 || IN_W > 10) begin : g_bad_in
         $error("sbu_tanh_lut: IN_W out of range");
      end
      if (OUT_W < 4 || OUT_W > 24) begin : g_bad_out
         $error("sbu_tanh_lut: OUT_W out of range");
      end
   endgenerate

   logic [IN_W-1:0] x_u;
   assign x_u = x;

   generate
      if (FOLD) begin : g_fold
         // positive half only; negative codes reuse it through odd symmetry
         logic signed [OUT_W-1:0] rom [HALF];
         logic        [IN_W-1:0]  mag;
         logic signed [OUT_W-1:0] pos;

         for (genvar g = 0; g < HALF; g++) begin : g_ent
            localparam longint ENT =
               sbu_pkg::lut_entry(longint'(g), FRAC_W, SAT_INT, OUT_W);
            assign rom[g] = ENT[OUT_W-1:0];
         end

         assign mag = x_u[IN_W-1] ? (~x_u + 1'b1) : x_u;
         assign pos = rom[mag];
         assign t   = x_u[IN_W-1] ? -pos : pos;
      end else begin : g_full
         logic signed [OUT_W-1:0] rom [DEPTH];

         for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            localparam longint VAL = (g >= DEPTH / 2) ?
                                     longint'(g) - longint'(DEPTH) : longint'(g);
            localparam longint ENT =
               sbu_pkg::lut_entry(VAL, FRAC_W, SAT_INT, OUT_W);
            assign rom[g] = ENT[OUT_W-1:0];
         end

         assign t = rom[x_u];
      end
   endgenerate

   // R4
   sign_agree_chk: assert final (!(x > 0 && t < 0) && !(x < 0 && t > 0));

endmodule

// File: rtl/sbu_decide.sv
`timescale 1ns/1ps
module sbu_decide #(
   parameter int OUT_W = 16,
   parameter int RND_W = 16
) (
   input  logic [RND_W-1:0]        rnd_state,
   input  logic signed [OUT_W-1:0] thresh,
   output logic                    go_pos,
   output logic [RND_W-OUT_W:0]    spare
);

   generate
      if (RND_W < OUT_W) begin : g_bad_w
         $error("sbu_decide: random width below threshold width");
      end
   endgenerate

   logic signed [OUT_W-1:0] r_frac;

   // top bits of the random state form the signed fraction
   assign r_frac = rnd_state[RND_W-1 -: OUT_W];

   generate
      if (RND_W > OUT_W) begin : g_wide
         assign spare = {1'b0, rnd_state[RND_W-OUT_W-1:0]};
      end else begin : g_eq
         assign spare = 1'b0;
      end
   endgenerate

   // equality goes to +1
   assign go_pos = (r_frac <= thresh);

endmodule

// File: rtl/stoch_bit_unit.sv
`timescale 1ns/1ps
module stoch_bit_unit #(
   parameter int               IN_W     = 8,
   parameter int               FRAC_W   = 4,
   parameter int               SAT_INT  = 4,
   parameter int               OUT_W    = 16,
   parameter int               RND_W    = 16,
   parameter logic [RND_W-1:0] RST_SEED = RND_W'(16'hACE1),
   parameter bit               LUT_FOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             upd_en,
   input  logic [IN_W-1:0]  drive_in,
   input  logic             seed_ld,
   input  logic [RND_W-1:0] seed_val,
   output logic             bit_out
);

   localparam int SAT_LIM = SAT_INT << FRAC_W;

   generate
      if (FRAC_W >= IN_W) begin : g_bad_frac
         $error("stoch_bit_unit: FRAC_W must be below IN_W");
      end
      if (SAT_LIM >= (1 << (IN_W - 1))) begin : g_bad_sat
         $error("stoch_bit_unit: saturation limit exceeds input range");
      end
   endgenerate

   logic [RND_W-1:0]        rnd_state;
   logic signed [OUT_W-1:0] thresh;
   logic                    go_pos;
   logic [RND_W-OUT_W:0]    spare;
   logic signed [IN_W-1:0]  drv_s;

   assign drv_s = drive_in;

   sbu_lfsr #(
      .W        (RND_W),
      .RST_SEED (RST_SEED)
   ) lfsr_i (
      .clk   (clk),
      .rst   (rst),
      .step  (upd_en),
      .load  (seed_ld),
      .seed  (seed_val),
      .state (rnd_state)
   );

   sbu_tanh_lut #(
      .IN_W    (IN_W),
      .FRAC_W  (FRAC_W),
      .SAT_INT (SAT_INT),
      .OUT_W   (OUT_W),
      .FOLD    (LUT_FOLD)
   ) lut_i (
      .x (drv_s),
      .t (thresh)
   );

   sbu_decide #(
      .OUT_W (OUT_W),
      .RND_W (RND_W)
   ) dec_i (
      .rnd_state (rnd_state),
      .thresh    (thresh),
      .go_pos    (go_pos),
      .spare     (spare)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_out <= 1'b1;
      end else if (upd_en) begin
         bit_out <= go_pos;
      end
   end

   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> $stable(bit_out));

   // R5
   sat_pos_chk: assert property (@(posedge clk) disable iff (rst)
      (upd_en && (int'(drv_s) > SAT_LIM)) |=> bit_out);

   // R5
   sat_thresh_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(drv_s) < -SAT_LIM) |-> (int'(thresh) == -((1 << (OUT_W - 1)) - 1)));

endmodule

// File: tb/stoch_bit_unit_tb_top.sv
`timescale 1ns/1ps
module stoch_bit_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        upd_en = 1'b0;
   logic [7:0]  drive_in = 8'd0;
   logic        seed_ld = 1'b0;
   logic [15:0] seed_val = 16'd0;
   logic        bit_out;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [15:0] mstate;

   always #2 clk = ~clk;

   stoch_bit_unit dut_i (
      .clk      (clk),
      .rst      (rst),
      .upd_en   (upd_en),
      .drive_in (drive_in),
      .seed_ld  (seed_ld),
      .seed_val (seed_val),
      .bit_out  (bit_out)
   );

   // {drive[7:0], seed[15:0]}
   localparam logic [23:0] VEC [9] = '{
      {8'h00, 16'h1234}, {8'h10, 16'hBEEF}, {8'hF0, 16'h0F0F},
      {8'h08, 16'h5A5A}, {8'hD8, 16'h7001}, {8'h40, 16'h0001},
      {8'hC0, 16'hFFFF}, {8'h7F, 16'h8888}, {8'h80, 16'h4321}
   };

   function automatic logic [15:0] lf_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic int thr(input logic [7:0] d);
      int v;
      v = int'($signed(d));
      if (v > 64) return 32767;
      if (v < -64) return -32767;
      return int'($floor($tanh(real'(v) / 16.0) * 32767.0 + 0.5));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // one strobe; compares against the model unless r is within 2 LSB of t
   task automatic do_update(input logic [7:0] d, input string req, output int val);
      int r;
      int t;
      bit e;
      r = int'($signed(mstate));
      t = thr(d);
      e = (r <= t);
      @(negedge clk);
      upd_en = 1'b1;
      drive_in = d;
      @(negedge clk);
      upd_en = 1'b0;
      mstate = lf_next(mstate);
      val = bit_out ? 1 : -1;
      if ((r - t > 2) || (t - r > 2)) check(bit_out == e, req, int'(bit_out), int'(e));
   endtask

   task automatic load_seed(input logic [15:0] s);
      @(negedge clk);
      seed_ld = 1'b1;
      seed_val = s;
      @(negedge clk);
      seed_ld = 1'b0;
      if (s != 16'd0) mstate = s;
   endtask

   task automatic run_avg(input logic [7:0] d, input int n, output real avg);
      int sum;
      int v;
      sum = 0;
      for (int k = 0; k < n; k++) begin
         do_update(d, "R3", v);
         sum += v;
      end
      avg = real'(sum) / real'(n);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      bit held;
      real a_neg;
      real a_zero;
      real a_pos;
      logic hold_val;

      mstate = 16'hACE1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset value
      check(bit_out == 1'b1, "R1", int'(bit_out), 1);
      // R1 reset seed observed through the first decisions
      for (int k = 0; k < 8; k++) do_update(8'h00, "R1", v);

      // table of vectors, R3 R4 R5 R6 R7
      for (int i = 0; i < 9; i++) begin
         load_seed(VEC[i][15:0]);
         for (int k = 0; k < 200; k++) do_update(VEC[i][23:16], "R4", v);
      end

      // R2 hold while drive changes and no strobe
      hold_val = bit_out;
      held = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         drive_in = (k % 2 == 0) ? 8'h7F : 8'h80;
         if (bit_out != hold_val) held = 1'b0;
      end
      check(held, "R2", int'(bit_out), int'(hold_val));
      // R6 no advance while idle: next decisions still follow the model
      for (int k = 0; k < 16; k++) do_update(8'h04, "R6", v);

      // R7 zero seed ignored
      load_seed(16'h0000);
      for (int k = 0; k < 16; k++) do_update(8'hFC, "R7", v);

      // R10 ties and R5 saturation
      load_seed(16'h7FFF);
      do_update(8'h7F, "R10", v);
      check(v == 1, "R10", v, 1);
      load_seed(16'h8001);
      do_update(8'h80, "R10", v);
      check(v == 1, "R10", v, 1);
      load_seed(16'h8002);
      do_update(8'h80, "R5", v);
      check(v == -1, "R5", v, -1);
      load_seed(16'h7FFF);
      do_update(8'h41, "R5", v);
      check(v == 1, "R5", v, 1);

      // R8 load and update in the same cycle
      load_seed(16'h0100);
      @(negedge clk);
      upd_en = 1'b1;
      drive_in = 8'h00;
      seed_ld = 1'b1;
      seed_val = 16'hF000;
      @(negedge clk);
      upd_en = 1'b0;
      seed_ld = 1'b0;
      check(bit_out == 1'b0, "R8", int'(bit_out), 0);
      mstate = 16'hF000;
      do_update(8'h00, "R8", v);
      check(v == 1, "R8", v, 1);

      // R9 long-run averages
      load_seed(16'h2468);
      run_avg(8'hF0, 1024, a_neg);
      run_avg(8'h00, 1024, a_zero);
      run_avg(8'h10, 1024, a_pos);
      check(a_zero < 0.08 && a_zero > -0.08, "R9", int'(a_zero * 1000.0), 0);
      check(a_pos > 0.68 && a_pos < 0.84, "R9", int'(a_pos * 1000.0), 762);
      check(a_neg < -0.68 && a_neg > -0.84, "R9", int'(a_neg * 1000.0), -762);
      check(a_neg < a_zero && a_zero < a_pos, "R9", int'(a_zero * 1000.0), 0);

      // R1 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(bit_out == 1'b1, "R1", int'(bit_out), 1);
      mstate = 16'hACE1;
      for (int k = 0; k < 8; k++) do_update(8'hE8, "R1", v);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule